// File: doc/BRIEF.md
# Packed-Decimal Declet Encoder

The block compresses binary-coded decimal operands into densely packed decimal declets. Each group of three BCD digits (12 bits) becomes one 10-bit declet, using the indicator-bit scheme. That scheme stores small digits (0 to 7) in three bits each and marks large digits (8 or 9) through the control bits. The encoder is replicated across the lanes of a 64-bit operand. Each 32-bit half takes six digits from its low 24 bits and yields two declets in its low 20 bits.

A lane that contains a nibble above 9 raises its own invalid flag. The declet produced for that lane carries no meaning. Results are registered: a word presented with `valid_i` appears one clock later with `valid_o`. The result registers keep their value while no new word is offered. Only canonical declets are ever produced, so a decoder downstream sees exactly one code per decimal value.

Top module: `bcd_dpd_pack`

## Requirements
- R1: In half h (h = 0, 1) and lane k (k = 0, 1), the digits at input bits [32h+12k+11 : 32h+12k] are read with hundreds at the top nibble, tens in the middle and units in the low nibble. The resulting declet sits at output bits [32h+10k+9 : 32h+10k]. Invalid flag bit 2h+k belongs to that lane.
- R2: Any value 000 to 079 encodes to the declet whose hex spelling equals the BCD spelling (for example 079 gives 0x079).
- R3: Every valid three-digit value 000 to 999 encodes to the unique canonical declet that decodes back to it. No output declet has bits [3:1] = 111 and bits [6:5] = 11 with bits [9:8] non-zero.
- R4: Fixed points: 080→0x00A, 088→0x04E, 800→0x00C, 880→0x00E, 888→0x06E, 999→0x0FF, 200→0x100, 700→0x380.
- R5: Output bits [31:20] of each half are always zero. Input bits [31:24] of each half have no effect on any output.
- R6: A lane's invalid flag is 1 exactly when one or more of its three nibbles exceeds 9. When it is set, the lane's declet is don't-care.
- R7: `valid_o` equals `valid_i` delayed by one clock. Declets and flags for a word offered with `valid_i` high appear in the clock after it is sampled.
- R8: While `valid_i` is low, `dpd_o` and `bad_o` hold their previous values whatever `bcd_i` carries.
- R9: During reset (`rst_ni` low, asynchronous), `valid_o`, `dpd_o` and `bad_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word is present |
| bcd_i | input | 64 | Two halves of six BCD digits each in bits [23:0] of the half |
| valid_o | output | 1 | Registered result is new |
| dpd_o | output | 64 | Two declets per half in bits [19:0] of the half, rest zero |
| bad_o | output | 4 | Per-lane flag for a nibble above 9 |

## Verification
The bench builds the block at its defaults: a 64-bit word, 32-bit halves and two declets per half. That gives four lanes, so placement across both halves and the twelve idle bits at the top of each half are all exercised. The expected code for every decimal value comes from inverting a behavioural decoder over all canonical declets. Each of the 1000 values is pushed through a lane, so the round trip is covered in full. Random illegal nibbles, junk in the idle input bits and gaps in `valid_i` test the flag, the masking and the hold behaviour.

// File: rtl/bcd_dpd_pkg.sv
package bcd_dpd_pkg;
  localparam int NIB_W     = 4;
  localparam int DIGITS    = 3;
  localparam int BCD3_W    = NIB_W * DIGITS;
  localparam int DECLET_W  = 10;
  typedef logic [NIB_W-1:0]    nib_t;
  typedef logic [BCD3_W-1:0]   bcd3_t;
  typedef logic [DECLET_W-1:0] declet_t;
endpackage

// File: rtl/dpd_nib_check.sv
module dpd_nib_check
  import bcd_dpd_pkg::*;
#(
  parameter int NIBS = DIGITS
) (
  input  logic [NIBS*NIB_W-1:0] bcd_i,
  output logic                  bad_o
);
  logic [NIBS-1:0] over;
  for (genvar n = 0; n < NIBS; n++) begin : g_nib
    assign over[n] = (bcd_i[n*NIB_W +: NIB_W] > nib_t'(9));
  end
  assign bad_o = |over;
endmodule

// File: rtl/dpd_declet_enc.sv
module dpd_declet_enc
  import bcd_dpd_pkg::*;
(
  input  bcd3_t   bcd_i,
  output declet_t dpd_o
);
  nib_t hun, ten, uni;
  assign hun = bcd_i[11:8];
  assign ten = bcd_i[7:4];
  assign uni = bcd_i[3:0];

  // large-digit indicators (digit is 8 or 9)
  logic [2:0] big;
  assign big = {hun[3], ten[3], uni[3]};

  always_comb begin
    unique case (big)
      3'b000: dpd_o = {hun[2:0], ten[2:0], 1'b0, uni[2:0]};
      3'b001: dpd_o = {hun[2:0], ten[2:0], 1'b1, 2'b00, uni[0]};
      3'b010: dpd_o = {hun[2:0], uni[2:1], ten[0], 1'b1, 2'b01, uni[0]};
      3'b011: dpd_o = {hun[2:0], 2'b10, ten[0], 1'b1, 2'b11, uni[0]};
      3'b100: dpd_o = {uni[2:1], hun[0], ten[2:0], 1'b1, 2'b10, uni[0]};
      3'b101: dpd_o = {ten[2:1], hun[0], 2'b01, ten[0], 1'b1, 2'b11, uni[0]};
      3'b110: dpd_o = {uni[2:1], hun[0], 2'b00, ten[0], 1'b1, 2'b11, uni[0]};
      default: dpd_o = {2'b00, hun[0], 2'b11, ten[0], 1'b1, 2'b11, uni[0]};
    endcase
  end

  always_comb begin
    // R3: never a redundant all-large code with non-zero top pair
    p_canonical_r3: assert (!(dpd_o[3:1] == 3'b111 && dpd_o[6:5] == 2'b11
                              && dpd_o[9:8] != 2'b00));
    // R2: all-small digits keep their low three bits in place
    if (hun < 4'd8 && ten < 4'd8 && uni < 4'd8)
      p_small_digits_r2: assert (dpd_o[3] == 1'b0 && dpd_o[2:0] == uni[2:0]
                                 && dpd_o[6:4] == ten[2:0]);
  end
endmodule

// File: rtl/dpd_half_pack.sv
module dpd_half_pack
  import bcd_dpd_pkg::*;
#(
  parameter int HALF_W  = 32,
  parameter int DECLETS = 2
) (
  input  logic [HALF_W-1:0]  half_i,
  output logic [HALF_W-1:0]  half_o,
  output logic [DECLETS-1:0] bad_o
);
  localparam int USED_IN  = DECLETS * BCD3_W;
  localparam int USED_OUT = DECLETS * DECLET_W;

  logic [USED_OUT-1:0] packed_w;

  for (genvar k = 0; k < DECLETS; k++) begin : g_lane
    dpd_declet_enc u_enc (
      .bcd_i (half_i[k*BCD3_W +: BCD3_W]),
      .dpd_o (packed_w[k*DECLET_W +: DECLET_W])
    );
    dpd_nib_check #(.NIBS(DIGITS)) u_chk (
      .bcd_i (half_i[k*BCD3_W +: BCD3_W]),
      .bad_o (bad_o[k])
    );
  end

  if (USED_OUT < HALF_W) begin : g_pad
    assign half_o = {{(HALF_W-USED_OUT){1'b0}}, packed_w};
  end else begin : g_nopad
    assign half_o = packed_w;
  end

  if (USED_IN < HALF_W) begin : g_idle
    logic unused_hi;
    assign unused_hi = ^half_i[HALF_W-1:USED_IN];
  end
endmodule

// File: rtl/bcd_dpd_pack.sv
module bcd_dpd_pack
  import bcd_dpd_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int HALF_W = 32,
  parameter int DPH    = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           valid_i,
  input  logic [WORD_W-1:0]              bcd_i,
  output logic                           valid_o,
  output logic [WORD_W-1:0]              dpd_o,
  output logic [(WORD_W/HALF_W)*DPH-1:0] bad_o
);
  localparam int HALVES   = WORD_W / HALF_W;
  localparam int LANES    = HALVES * DPH;
  localparam int USED_OUT = DPH * DECLET_W;

  logic [WORD_W-1:0] enc_w;
  logic [LANES-1:0]  bad_w;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    dpd_half_pack #(.HALF_W(HALF_W), .DECLETS(DPH)) u_half (
      .half_i (bcd_i[h*HALF_W +: HALF_W]),
      .half_o (enc_w[h*HALF_W +: HALF_W]),
      .bad_o  (bad_w[h*DPH +: DPH])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dpd_o   <= '0;
      bad_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        dpd_o <= enc_w;
        bad_o <= bad_w;
      end
    end
  end

  p_valid_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(dpd_o) && $stable(bad_o)));

  if (USED_OUT < HALF_W) begin : g_chk_pad
    for (genvar h = 0; h < HALVES; h++) begin : g_h
      p_unused_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (dpd_o[h*HALF_W+USED_OUT +: HALF_W-USED_OUT] == '0));
    end
  end
endmodule

// File: tb/bcd_dpd_pack_bench.sv
module bcd_dpd_pack_bench;
  localparam int WORD_W = 64;
  localparam int HALF_W = 32;
  localparam int DPH    = 2;
  localparam int LANES  = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_ni;
  logic              valid_i;
  logic [WORD_W-1:0] bcd_i;
  logic              valid_o;
  logic [WORD_W-1:0] dpd_o;
  logic [LANES-1:0]  bad_o;

  bcd_dpd_pack #(.WORD_W(WORD_W), .HALF_W(HALF_W), .DPH(DPH)) u_bcd_dpd_pack (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .bcd_i(bcd_i),
    .valid_o(valid_o), .dpd_o(dpd_o), .bad_o(bad_o)
  );

  int checks = 0;
  int failures = 0;
  int enc_tab[1000];

  logic             m_valid;
  logic [9:0]       m_dec[LANES];
  logic [LANES-1:0] m_bad;
  logic [LANES-1:0] m_care;
  int               m_val[LANES];
  string            tag;

  function automatic bit noncanon(logic [9:0] c);
    return c[3:1] == 3'b111 && c[6:5] == 2'b11 && c[9:8] != 2'b00;
  endfunction

  // behavioural decoder: declet -> three BCD digits
  function automatic logic [11:0] dec_declet(logic [9:0] c);
    logic [3:0] h, t, u;
    logic p, q, r, s, tt, uu, w, x, y;
    {p, q, r, s, tt, uu} = c[9:4];
    {w, x, y} = c[2:0];
    if (!c[3]) begin
      h = {1'b0, p, q, r}; t = {1'b0, s, tt, uu}; u = {1'b0, w, x, y};
    end else begin
      case ({w, x})
        2'b00: begin h = {1'b0,p,q,r}; t = {1'b0,s,tt,uu}; u = {3'b100,y}; end
        2'b01: begin h = {1'b0,p,q,r}; t = {3'b100,uu}; u = {1'b0,s,tt,y}; end
        2'b10: begin h = {3'b100,r}; t = {1'b0,s,tt,uu}; u = {1'b0,p,q,y}; end
        default: begin
          case ({s, tt})
            2'b00: begin h = {3'b100,r}; t = {3'b100,uu}; u = {1'b0,p,q,y}; end
            2'b01: begin h = {3'b100,r}; t = {1'b0,p,q,uu}; u = {3'b100,y}; end
            2'b10: begin h = {1'b0,p,q,r}; t = {3'b100,uu}; u = {3'b100,y}; end
            default: begin h = {3'b100,r}; t = {3'b100,uu}; u = {3'b100,y}; end
          endcase
        end
      endcase
    end
    return {h, t, u};
  endfunction

  function automatic logic [11:0] to_bcd(int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int lane_base(int l);
    return (l / DPH) * HALF_W + (l % DPH) * 12;
  endfunction
  function automatic int out_base(int l);
    return (l / DPH) * HALF_W + (l % DPH) * 10;
  endfunction

  task automatic compare();
    string lt;
    chk("R7 valid_o", 64'(valid_o), 64'(m_valid));
    chk("R6 bad_o", 64'(bad_o), 64'(m_bad));
    for (int h = 0; h < 2; h++)
      chk("R5 idle output bits", 64'(dpd_o[h*HALF_W+20 +: 12]), 64'd0);
    for (int l = 0; l < LANES; l++) begin
      if (m_care[l]) begin
        if (tag != "") lt = tag;
        else if (m_val[l] < 80) lt = "R2";
        else lt = "R3";
        chk({lt, " declet"}, 64'(dpd_o[out_base(l) +: 10]), 64'(m_dec[l]));
        chk("R3 canonical", 64'(noncanon(dpd_o[out_base(l) +: 10])), 64'd0);
      end
    end
  endtask

  // one clock step: check last result, then offer next word
  task automatic step(bit v, logic [63:0] w);
    @(negedge clk);
    compare();
    valid_i = v;
    bcd_i = w;
    m_valid = v;
    if (v) begin
      for (int l = 0; l < LANES; l++) begin
        logic [11:0] b;
        b = w[lane_base(l) +: 12];
        m_bad[l] = (b[11:8] > 9) || (b[7:4] > 9) || (b[3:0] > 9);
        m_care[l] = !m_bad[l];
        if (!m_bad[l]) begin
          m_val[l] = int'(b[11:8]) * 100 + int'(b[7:4]) * 10 + int'(b[3:0]);
          m_dec[l] = 10'(enc_tab[m_val[l]]);
        end
      end
    end
  endtask

  function automatic logic [63:0] pack4(int a, int b, int c, int d, logic [15:0] junk);
    logic [63:0] w;
    w = '0;
    w[11:0]  = to_bcd(a);
    w[23:12] = to_bcd(b);
    w[43:32] = to_bcd(c);
    w[55:44] = to_bcd(d);
    w[31:24] = junk[7:0];
    w[63:56] = junk[15:8];
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int d = 0; d < 1024; d++) begin
      if (!noncanon(10'(d))) begin
        logic [11:0] b;
        b = dec_declet(10'(d));
        enc_tab[int'(b[11:8]) * 100 + int'(b[7:4]) * 10 + int'(b[3:0])] = d;
      end
    end
    tag = "";
    m_valid = 0; m_bad = '0; m_care = '0;
    for (int l = 0; l < LANES; l++) begin m_dec[l] = '0; m_val[l] = 0; end
    rst_ni = 0; valid_i = 0; bcd_i = '1;
    repeat (3) @(negedge clk);
    chk("R9 reset valid_o", 64'(valid_o), 64'd0);
    chk("R9 reset dpd_o", dpd_o, 64'd0);
    chk("R9 reset bad_o", 64'(bad_o), 64'd0);
    rst_ni = 1;

    // R4 fixed points
    tag = "R4";
    step(1, pack4(80, 88, 800, 880, 16'h0));
    step(1, pack4(888, 999, 200, 700, 16'h0));
    // R1 placement with distinct lanes
    tag = "R1";
    step(1, pack4(123, 456, 789, 902, 16'h0));
    step(1, pack4(7, 79, 981, 98, 16'h0));
    tag = "";
    // R3/R2 full round trip over every value, junk in idle bits (R5)
    for (int v = 0; v < 1000; v++)
      step(1, pack4(v, 999 - v, (v * 7) % 1000, (v * 13 + 5) % 1000,
                    16'($urandom)));
    // R8 hold: valid low with changing input
    tag = "R8";
    for (int i = 0; i < 20; i++)
      step(0, {$urandom, $urandom});
    tag = "";
    // R6 illegal nibbles mixed with legal lanes, gaps in valid (R7)
    for (int i = 0; i < 400; i++)
      step((i % 5) != 4, {$urandom, $urandom});
    step(0, '0);
    step(0, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule